// File: doc/BRIEF.md
# Two-Stage Delay Lock Sequencer with Duty-Cycle Trim

This block is the digital half of a delay-locked loop that also fixes the duty cycle of a divide-by-two clock. Two single-bit early/late samplers sit outside it. One compares the rising feedback edge with the reference. The other compares the opposite feedback edge with the next reference rising edge. Each sampler gives one verdict per feedback period, and a strobe marks the cycle in which those verdicts are valid. Because the controlled clock is halved, the strobe arrives at most every other cycle.

Locking happens in a fixed order. First the rising-edge loop steers a wide delay word. That word is a coarse tap count, where each tap is two gate delays, with an interpolation weight below it. When this loop locks, the word is frozen. The second loop then steers a narrow fine-only word that places the opposite edge, and this sets the duty cycle. A loop counts as locked when its verdicts keep flipping. If the second loop runs into either end of its range, the input duty cycle is taken to be outside what the trim can reach, and a failure flag is raised.

Top module: `dll_lock_ctrl`

## Requirements
- R1: While reset is held and just after it, `d1_code` is 0, `d2_code` is at the middle of its range (2^(FW-1), 8 by default), and `lock_rise`, `lock_fall` and `lock_fail` are all 0.
- R2: In a cycle where `sample_en` is 0, the verdict inputs are ignored. Neither code moves and no lock state changes.
- R3: Before `lock_rise`, a strobed `pd_rise` of 1 (reference ahead) raises `d1_code` by one on that clock edge, and a 0 lowers it by one.
- R4: `d1_code` is a single binary word, with the coarse field in the upper CW bits and the fine field in the lower FW bits. A fine field going past all ones carries into the coarse field (15 then 16 by default), and stepping down from fine zero borrows from it.
- R5: `d1_code` saturates: it stays at 0 on a lag verdict and at all ones (511 by default) on a lead verdict, and never wraps.
- R6: Until `lock_rise` is 1, `d2_code` holds its reset value whatever `pd_fall` does.
- R7: Each loop splits its strobed verdicts into consecutive groups of 8, counted from its first verdict. A reversal is a verdict that differs from that loop's previous one. If a group ends with at least 4 reversals, the loop's lock flag rises on that edge and stays set until reset. The verdict that closes the group is still applied to the code.
- R8: Once `lock_rise` is 1, `d1_code` never changes.
- R9: Once `lock_rise` is 1, and until `lock_fall` or `lock_fail` is set, a strobed `pd_fall` of 1 raises `d2_code` by one and a 0 lowers it by one.
- R10: If a strobed loop-2 verdict would push `d2_code` past 15 or below 0, `d2_code` is left unchanged and `lock_fail` is set and stays set. That verdict does not count toward lock, `lock_fall` never rises, and the code stays frozen from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| sample_en | input | 1 | High in a cycle in which both verdicts are valid |
| pd_rise | input | 1 | Rising-edge verdict: 1 means reference leads |
| pd_fall | input | 1 | Opposite-edge verdict: 1 means reference leads |
| d1_code | output | CW+FW | Rising-edge delay word {coarse, fine} |
| d2_code | output | FW | Opposite-edge fine delay word |
| lock_rise | output | 1 | Loop 1 locked |
| lock_fall | output | 1 | Loop 2 locked |
| lock_fail | output | 1 | Loop 2 ran out of range |

## Verification
The hardest states to reach are the code extremes and a clean second-stage failure. Reaching them needs long runs of same-sign verdicts without setting off the reversal-based lock. The bench therefore pushes hundreds of one-direction decisions to hit both saturation ends of the wide word. It then closes the loop against a linear code-to-edge-time model, using targets for several duty cycles. Duty values whose loop-2 target lies outside 0 to 15 drive the fine word into a wall before any group can contain enough reversals.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_RISE = 2'd0,
    PH_FALL = 2'd1,
    PH_DONE = 2'd2,
    PH_FAIL = 2'd3
  } lock_phase_e;
endpackage

// File: rtl/dll_sat_code.sv
module dll_sat_code #(
  parameter int W    = 4,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         step_en,
  input  logic         step_up,
  output logic [W-1:0] code,
  output logic         at_wall
);
  localparam logic [W-1:0] CMAX  = {W{1'b1}};
  localparam logic [W-1:0] CINIT = W'(INIT);

  logic [W-1:0] code_q, code_d;

  // a step against the end of range is refused
  assign at_wall = step_en && (step_up ? (code_q == CMAX) : (code_q == '0));

  always_comb begin
    code_d = code_q;
    if (step_en && !at_wall) begin
      if (step_up) code_d = code_q + W'(1);
      else         code_d = code_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      code_q <= CINIT;
    else if (step_en) code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/dll_flip_det.sv
module dll_flip_det #(
  parameter int WIN     = 8,
  parameter int REV_MIN = 4
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic dec_en,
  input  logic dec,
  output logic lock_hit
);
  localparam int CNTW = $clog2(WIN);
  localparam int REVW = $clog2(WIN + 1);
  localparam logic [CNTW-1:0] CLAST = CNTW'(WIN - 1);
  localparam logic [REVW-1:0] RMIN  = REVW'(REV_MIN);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [REVW-1:0] rev_q, rev_d, rev_sum;
  logic            prev_q, seen_q;
  logic            flip;

  assign flip    = seen_q && (dec != prev_q);
  assign rev_sum = rev_q + REVW'(flip);
  assign lock_hit = dec_en && (cnt_q == CLAST) && (rev_sum >= RMIN);

  always_comb begin
    cnt_d = cnt_q;
    rev_d = rev_q;
    if (dec_en) begin
      if (cnt_q == CLAST) begin
        cnt_d = '0;
        rev_d = '0;
      end else begin
        cnt_d = cnt_q + CNTW'(1);
        rev_d = rev_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rev_q  <= '0;
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (dec_en) begin
      cnt_q  <= cnt_d;
      rev_q  <= rev_d;
      prev_q <= dec;
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dll_lock_ctrl.sv
module dll_lock_ctrl
  import dll_ctrl_pkg::*;
#(
  parameter int CW      = 5,
  parameter int FW      = 4,
  parameter int WIN     = 8,
  parameter int REV_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             pd_rise,
  input  logic             pd_fall,
  output logic [CW+FW-1:0] d1_code,
  output logic [FW-1:0]    d2_code,
  output logic             lock_rise,
  output logic             lock_fall,
  output logic             lock_fail
);
  localparam int D1W  = CW + FW;
  localparam int D2MID = 1 << (FW - 1);

  // reset: asserted at once, removed on a clock edge
  logic rs_q0, rs_q1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q0 <= 1'b0;
      rs_q1 <= 1'b0;
    end else begin
      rs_q0 <= 1'b1;
      rs_q1 <= rs_q0;
    end
  end

  lock_phase_e ph_q, ph_d;
  logic en1, en2, wall1, wall2, hit1, hit2;

  assign en1 = sample_en && (ph_q == PH_RISE);
  assign en2 = sample_en && (ph_q == PH_FALL);

  dll_sat_code #(.W(D1W), .INIT(0)) u_code1 (
    .clk(clk), .rst_ni(rs_q1), .step_en(en1), .step_up(pd_rise),
    .code(d1_code), .at_wall(wall1)
  );

  dll_sat_code #(.W(FW), .INIT(D2MID)) u_code2 (
    .clk(clk), .rst_ni(rs_q1), .step_en(en2), .step_up(pd_fall),
    .code(d2_code), .at_wall(wall2)
  );

  dll_flip_det #(.WIN(WIN), .REV_MIN(REV_MIN)) u_det1 (
    .clk(clk), .rst_ni(rs_q1), .dec_en(en1), .dec(pd_rise), .lock_hit(hit1)
  );

  dll_flip_det #(.WIN(WIN), .REV_MIN(REV_MIN)) u_det2 (
    .clk(clk), .rst_ni(rs_q1), .dec_en(en2 && !wall2), .dec(pd_fall),
    .lock_hit(hit2)
  );

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_RISE: if (hit1) ph_d = PH_FALL;
      PH_FALL: begin
        if (wall2)     ph_d = PH_FAIL;
        else if (hit2) ph_d = PH_DONE;
      end
      default: ph_d = ph_q;
    endcase
  end

  always_ff @(posedge clk or negedge rs_q1) begin
    if (!rs_q1)         ph_q <= PH_RISE;
    else if (sample_en) ph_q <= ph_d;
  end

  assign lock_rise = (ph_q != PH_RISE);
  assign lock_fall = (ph_q == PH_DONE);
  assign lock_fail = (ph_q == PH_FAIL);
endmodule

// File: rtl/dll_lock_ctrl_chk.sv
module dll_lock_ctrl_chk #(
  parameter int CW = 5,
  parameter int FW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic [CW+FW-1:0] d1_code,
  input logic [FW-1:0]    d2_code,
  input logic             lock_rise,
  input logic             lock_fall,
  input logic             lock_fail
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(d1_code) && $stable(d2_code) && $stable(lock_rise)));

  p_d1_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !lock_rise) |=>
      ((d1_code == $past(d1_code)) || (d1_code == $past(d1_code) + 1'b1) ||
       (d1_code == $past(d1_code) - 1'b1)));

  p_d2_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_rise |=> $stable(d2_code));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rise |=> lock_rise);

  p_d1_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_rise |=> $stable(d1_code));

  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fail |=> (lock_fail && $stable(d2_code)));

  p_fail_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_fail && lock_fall));
endmodule

bind dll_lock_ctrl dll_lock_ctrl_chk #(.CW(CW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .d1_code(d1_code),
  .d2_code(d2_code), .lock_rise(lock_rise), .lock_fall(lock_fall),
  .lock_fail(lock_fail)
);

// File: tb/dll_lock_ctrl_tb_top.sv
`timescale 1ns/1ps
module dll_lock_ctrl_tb_top;
  localparam int CW = 5;
  localparam int FW = 4;
  localparam int D1MAX = (1 << (CW + FW)) - 1;
  localparam int D2MAX = (1 << FW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic pd_rise = 1'b0;
  logic pd_fall = 1'b0;
  logic [CW+FW-1:0] d1_code;
  logic [FW-1:0] d2_code;
  logic lock_rise, lock_fall, lock_fail;

  always #10 clk = ~clk;

  dll_lock_ctrl #(.CW(CW), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .pd_rise(pd_rise),
    .pd_fall(pd_fall), .d1_code(d1_code), .d2_code(d2_code),
    .lock_rise(lock_rise), .lock_fall(lock_fall), .lock_fail(lock_fail)
  );

  int total = 0;
  int bad = 0;

  // behavioural reference model
  int m_d1, m_d2, m_ph;
  int w_cnt[2], w_rev[2], w_prev[2], w_seen[2];

  function automatic bit win_step(int k, bit d);
    int r;
    bit h;
    r = (w_seen[k] != 0 && d != w_prev[k]) ? 1 : 0;
    h = 1'b0;
    if (w_cnt[k] == 7) begin
      h = (w_rev[k] + r) >= 4;
      w_cnt[k] = 0;
      w_rev[k] = 0;
    end else begin
      w_cnt[k]++;
      w_rev[k] += r;
    end
    w_prev[k] = d;
    w_seen[k] = 1;
    return h;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d1 = 0; m_d2 = 8; m_ph = 0;
      for (int k = 0; k < 2; k++) begin
        w_cnt[k] = 0; w_rev[k] = 0; w_prev[k] = 0; w_seen[k] = 0;
      end
    end else if (sample_en) begin
      if (m_ph == 0) begin
        bit h;
        h = win_step(0, pd_rise);
        if (pd_rise && m_d1 < D1MAX) m_d1++;
        else if (!pd_rise && m_d1 > 0) m_d1--;
        if (h) m_ph = 1;
      end else if (m_ph == 1) begin
        bit h;
        if (pd_fall ? (m_d2 == D2MAX) : (m_d2 == 0)) m_ph = 3;
        else begin
          h = win_step(1, pd_fall);
          m_d2 += pd_fall ? 1 : -1;
          if (h) m_ph = 2;
        end
      end
    end
  end

  task automatic chk(input int got, input int exp, input string tag);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (d1_code != m_d1[CW+FW-1:0] || d2_code != m_d2[FW-1:0] ||
          lock_rise != (m_ph != 0) || lock_fall != (m_ph == 2) ||
          lock_fail != (m_ph == 3)) begin
        bad++;
        $display("FAIL R2 R3 R9 cycle compare got d1=%0d d2=%0d f=%b%b%b exp d1=%0d d2=%0d ph=%0d",
                 d1_code, d2_code, lock_rise, lock_fall, lock_fail, m_d1, m_d2, m_ph);
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    sample_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic decide(input bit a, input bit b);
    @(negedge clk);
    sample_en = 1'b1; pd_rise = a; pd_fall = b;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic close_loop(input int t1, input int t2, input int n, input int stop_sel);
    for (int i = 0; i < n; i++) begin
      if (stop_sel == 1 && m_ph != 0) break;
      if (stop_sel == 2 && m_ph >= 2) break;
      decide(m_d1 < t1, m_d2 < t2);
    end
  endtask

  task automatic run_duty(input int t1, input int duty);
    int t2, d1_seen, d2_seen;
    t2 = 8 + (duty - 50) / 4;
    do_reset();
    close_loop(t1, t2, 1200, 1);
    @(negedge clk);
    chk(lock_rise, 1, "R7 loop1 lock");
    chk((d1_code >= t1 - 1 && d1_code <= t1) ? 1 : 0, 1, "R3 d1 near target");
    d1_seen = d1_code;
    close_loop(t1 + 50, t2, 200, 2);
    @(negedge clk);
    chk(d1_code, d1_seen, "R8 d1 frozen");
    if (t2 >= 0 && t2 <= D2MAX) begin
      chk(lock_fall, 1, "R9 loop2 lock");
      chk((d2_code >= t2 - 1 && d2_code <= t2) ? 1 : 0, 1, "R9 d2 near target");
    end else begin
      chk(lock_fail, 1, "R10 fail raised");
      chk(lock_fall, 0, "R10 no loop2 lock");
      chk(d2_code, (t2 > D2MAX) ? D2MAX : 0, "R10 d2 at wall");
    end
    d2_seen = d2_code;
    for (int i = 0; i < 10; i++) decide(i[0], ~i[0]);
    @(negedge clk);
    chk(d2_code, d2_seen, "R10 R9 d2 held after end");
    chk(lock_rise, 1, "R7 sticky");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk(d1_code, 0, "R1 d1 reset");
    chk(d2_code, 8, "R1 d2 reset");
    chk({lock_rise, lock_fall, lock_fail}, 0, "R1 flags reset");

    for (int i = 0; i < 6; i++) begin
      @(negedge clk); pd_rise = ~pd_rise; pd_fall = pd_rise;
    end
    @(negedge clk);
    chk(d1_code, 0, "R2 no strobe no move");

    for (int i = 0; i < 16; i++) decide(1'b1, i[0]);
    @(negedge clk);
    chk(d1_code, 16, "R4 fine carry into coarse");
    chk(d2_code, 8, "R6 d2 idle before lock");
    decide(1'b0, 1'b1);
    @(negedge clk);
    chk(d1_code, 15, "R4 borrow from coarse");
    for (int i = 0; i < 20; i++) decide(1'b0, 1'b0);
    @(negedge clk);
    chk(d1_code, 0, "R5 saturate low");
    for (int i = 0; i < 520; i++) decide(1'b1, 1'b1);
    @(negedge clk);
    chk(d1_code, D1MAX, "R5 saturate high");
    chk(lock_rise, 0, "R7 no lock without reversals");
    chk(d2_code, 8, "R6 d2 still idle");

    run_duty(200, 50);
    run_duty(37, 30);
    run_duty(300, 70);
    run_duty(120, 90);
    run_duty(80, 10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule